// File: doc/BRIEF.md
# Passive Serial FPGA Configuration Master

This block loads a configuration bitstream into an SRAM-based FPGA over a five-wire passive serial link. It drives three lines: an active-low program request, a serial clock and a serial data line. It watches two lines coming back from the target: a ready/status line and a configuration-complete line. Configuration bytes arrive on a valid/ready byte stream, and a `last` flag marks the final byte of the image. The controlling logic starts a cycle with a one-cycle `start_i` pulse. It then sees `busy_o` while the cycle runs, and on completion either `done_o` or `err_o` together with a cause code.

A cycle runs as follows. The master holds the program line low for a fixed number of system clocks and then releases it. It waits for the target's status line to go high. It then serialises each byte least significant bit first. The data line changes only while the serial clock is low, so the target captures each bit on the rising edge. When the target reports completion, the master sends a fixed count of trailing clocks, which the target needs to initialise. The serial clock stays low while the master waits for input data, because the link has no minimum rate.

Three fault cases end a cycle with an error. The first is a status line that never rises. The second is a status line that drops during the transfer. The third is a stream that ends without the completion line rising within a bounded number of extra clocks.

Top module: `psc_master`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `prog_n_o` is 1, `dclk_o` is 0 and `byte_ready_o` is 0. Directly after reset, `done_o`, `err_o` and `err_code_o` are 0.
- R2: A `start_i` pulse while idle drives `prog_n_o` low for exactly PULSE_LEN system clocks and raises `busy_o`. A `start_i` pulse while `busy_o` is high has no effect: there is no second low pulse on `prog_n_o` and the transfer is not disturbed.
- R3: After `prog_n_o` is released, no byte is accepted and no rising edge appears on `dclk_o` until `tgt_ready_i` has been seen high.
- R4: Each accepted byte appears on `dat_o` least significant bit first, one bit per `dclk_o` rising edge. `dat_o` is stable while `dclk_o` is high. For example, 0x02 is seen as 0,1,0,0,0,0,0,0.
- R5: While shifting, every high phase of `dclk_o` lasts exactly DIV system clocks. While the master waits for an input byte (`byte_ready_o` high), `dclk_o` is held low, for as long as the wait lasts.
- R6: Once `tgt_done_i` is seen high, shifting stops after the current bit. No further input bytes are accepted.
- R7: After `tgt_done_i` is seen, exactly TRAIL_CLKS (default 2) further rising edges appear on `dclk_o`. Then `busy_o` falls and `done_o` rises with `err_o` low. If completion is seen on the final bit of the last byte, this normal finish takes priority over the end-of-stream handling.
- R8: If `tgt_ready_i` is not seen high within RDY_TIMEOUT clocks of the release, the cycle aborts with `err_code_o` = 1. No byte is consumed and no clock edge is sent.
- R9: If `tgt_ready_i` drops after it was seen high, the cycle aborts with `err_code_o` = 2. `dclk_o` returns low and no further rising edge is sent.
- R10: If the stream ends without completion, up to TAIL_LIMIT extra `dclk_o` pulses are sent with `dat_o` at 0. If completion arrives during them, the cycle ends as in R7. Otherwise it ends with `err_code_o` = 3 after exactly TAIL_LIMIT extra rising edges.
- R11: Starting a new cycle clears `done_o`, `err_o` and `err_code_o` on the same edge that raises `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a configuration cycle (ignored while busy) |
| byte_data_i | input | 8 | Configuration byte |
| byte_valid_i | input | 1 | Byte on `byte_data_i` is valid |
| byte_last_i | input | 1 | The offered byte is the final one of the image |
| byte_ready_o | output | 1 | Master accepts the offered byte this cycle |
| prog_n_o | output | 1 | Active-low program request to the target |
| dclk_o | output | 1 | Serial configuration clock, idles low |
| dat_o | output | 1 | Serial configuration data |
| tgt_ready_i | input | 1 | Target status, high when ready to receive |
| tgt_done_i | input | 1 | Target configuration-complete flag |
| busy_o | output | 1 | A configuration cycle is in progress |
| done_o | output | 1 | Last cycle finished successfully |
| err_o | output | 1 | Last cycle ended in an error |
| err_code_o | output | 2 | Error cause: 0 none, 1 ready timeout, 2 status lost, 3 no completion |

## Verification
Completion detection and end-of-stream detection can fall on the same `dclk_o` falling edge. This happens when the target raises its completion flag on the final bit of the last byte. The bench provokes this by programming its target model to complete after exactly as many bits as the image contains. It then judges the result at the ports: the number of extra rising edges must equal the trailing count, with no drain pulses, and `done_o` must rise without an error code. Separate runs move completion earlier (mid-stream) and later (inside the drain window), so each ordering of the two events is covered.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAIT,
        ST_FETCH,
        ST_SHIFT,
        ST_DRAIN,
        ST_TAIL
    } psc_state_e;

    typedef enum logic [1:0] {
        ERR_NONE        = 2'd0,
        ERR_NO_READY    = 2'd1,
        ERR_STATUS_LOST = 2'd2,
        ERR_NO_DONE     = 2'd3
    } psc_err_e;

endpackage

// File: rtl/psc_sync.sv
// Multi-stage synchroniser, one chain per input bit.
module psc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/psc_tick.sv
// Half-period strobe: fires once every DIV enabled cycles.
module psc_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    if (DIV == 1) begin : g_direct
        assign tick_o = en_i;
    end else begin : g_count
        localparam int CW = $clog2(DIV);
        localparam logic [CW-1:0] LAST = CW'(DIV - 1);
        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            if (!en_i)              cnt_d = '0;
            else if (cnt_q == LAST) cnt_d = '0;
            else                    cnt_d = cnt_q + 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign tick_o = en_i && (cnt_q == LAST);
    end
endmodule

// File: rtl/psc_timer.sv
// Loadable down-counter that rests at zero.
module psc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)          cnt_d = val_i;
        else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
        else                 cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/psc_serializer.sv
// Byte holder that presents bits least significant first.
module psc_serializer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         last_i,
    input  logic         adv_i,
    output logic         bit_o,
    output logic         final_bit_o,
    output logic         last_byte_o
);
    localparam int IW = $clog2(W);

    typedef struct packed {
        logic [W-1:0]  data;
        logic [IW-1:0] idx;
        logic          last;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.data = data_i;
            s_d.idx  = '0;
            s_d.last = last_i;
        end else if (adv_i) begin
            s_d.data = {1'b0, s_q.data[W-1:1]};
            s_d.idx  = s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bit_o       = s_q.data[0];
    assign final_bit_o = (s_q.idx == IW'(W - 1));
    assign last_byte_o = s_q.last;
endmodule

// File: rtl/psc_master.sv
module psc_master
    import psc_pkg::*;
#(
    parameter int DIV         = 4,
    parameter int PULSE_LEN   = 8,
    parameter int RDY_TIMEOUT = 64,
    parameter int TAIL_LIMIT  = 6,
    parameter int TRAIL_CLKS  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] byte_data_i,
    input  logic       byte_valid_i,
    input  logic       byte_last_i,
    output logic       byte_ready_o,
    output logic       prog_n_o,
    output logic       dclk_o,
    output logic       dat_o,
    input  logic       tgt_ready_i,
    input  logic       tgt_done_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic [1:0] err_code_o
);
    localparam int BYTE_W = 8;
    localparam int TMAX   = (PULSE_LEN > RDY_TIMEOUT) ? PULSE_LEN : RDY_TIMEOUT;
    localparam int TW     = $clog2(TMAX + 1);
    localparam int PMAX   = (TAIL_LIMIT > TRAIL_CLKS) ? TAIL_LIMIT : TRAIL_CLKS;
    localparam int PW     = $clog2(PMAX + 1);
    localparam logic [PW-1:0] P_TRAIL = PW'(TRAIL_CLKS);
    localparam logic [PW-1:0] P_LIMIT = PW'(TAIL_LIMIT);
    localparam logic [PW-1:0] P_ONE   = PW'(1);

    typedef struct packed {
        psc_state_e    st;
        logic          prog_n;
        logic          dclk;
        logic          done;
        psc_err_e      err;
        logic [PW-1:0] pcnt;
    } ctl_t;

    ctl_t q, n;

    logic          rdy_s, done_s;
    logic          tick, tick_en, lo_end, hi_end;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          ser_load, ser_adv, ser_bit, ser_final, ser_last;

    psc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({tgt_done_i, tgt_ready_i}),
        .q_o   ({done_s, rdy_s})
    );

    psc_tick #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tick_en),
        .tick_o (tick)
    );

    psc_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    psc_serializer #(.W(BYTE_W)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (ser_load),
        .data_i      (byte_data_i),
        .last_i      (byte_last_i),
        .adv_i       (ser_adv),
        .bit_o       (ser_bit),
        .final_bit_o (ser_final),
        .last_byte_o (ser_last)
    );

    assign tick_en = (q.st == ST_SHIFT) || (q.st == ST_DRAIN) || (q.st == ST_TAIL);
    assign lo_end  = tick && !q.dclk;
    assign hi_end  = tick &&  q.dclk;

    always_comb begin
        n        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ser_load = 1'b0;
        ser_adv  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    n.st     = ST_PULSE;
                    n.prog_n = 1'b0;
                    n.done   = 1'b0;
                    n.err    = ERR_NONE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PULSE_LEN - 1);
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    n.st     = ST_WAIT;
                    n.prog_n = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RDY_TIMEOUT - 1);
                end
            end
            ST_WAIT: begin
                if (rdy_s) begin
                    n.st = ST_FETCH;
                end else if (tmr_zero) begin
                    n.st  = ST_IDLE;
                    n.err = ERR_NO_READY;
                end
            end
            ST_FETCH: begin
                if (!rdy_s) begin
                    n.st   = ST_IDLE;
                    n.dclk = 1'b0;
                    n.err  = ERR_STATUS_LOST;
                end else if (byte_valid_i) begin
                    ser_load = 1'b1;
                    n.st     = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (!rdy_s) begin
                    n.st   = ST_IDLE;
                    n.dclk = 1'b0;
                    n.err  = ERR_STATUS_LOST;
                end else if (lo_end) begin
                    n.dclk = 1'b1;
                end else if (hi_end) begin
                    n.dclk = 1'b0;
                    // completion outranks end-of-stream on the same edge
                    if (done_s) begin
                        n.st   = ST_TAIL;
                        n.pcnt = P_TRAIL;
                    end else if (ser_final) begin
                        if (ser_last) begin
                            n.st   = ST_DRAIN;
                            n.pcnt = P_LIMIT;
                        end else begin
                            n.st = ST_FETCH;
                        end
                    end else begin
                        ser_adv = 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (!rdy_s) begin
                    n.st   = ST_IDLE;
                    n.dclk = 1'b0;
                    n.err  = ERR_STATUS_LOST;
                end else if (lo_end) begin
                    n.dclk = 1'b1;
                end else if (hi_end) begin
                    n.dclk = 1'b0;
                    if (done_s) begin
                        n.st   = ST_TAIL;
                        n.pcnt = P_TRAIL;
                    end else if (q.pcnt == P_ONE) begin
                        n.st  = ST_IDLE;
                        n.err = ERR_NO_DONE;
                    end else begin
                        n.pcnt = q.pcnt - P_ONE;
                    end
                end
            end
            ST_TAIL: begin
                if (!rdy_s) begin
                    n.st   = ST_IDLE;
                    n.dclk = 1'b0;
                    n.err  = ERR_STATUS_LOST;
                end else if (lo_end) begin
                    n.dclk = 1'b1;
                end else if (hi_end) begin
                    n.dclk = 1'b0;
                    if (q.pcnt == P_ONE) begin
                        n.st   = ST_IDLE;
                        n.done = 1'b1;
                    end else begin
                        n.pcnt = q.pcnt - P_ONE;
                    end
                end
            end
            default: begin
                n.st     = ST_IDLE;
                n.dclk   = 1'b0;
                n.prog_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.prog_n <= 1'b1;
            q.dclk   <= 1'b0;
            q.done   <= 1'b0;
            q.err    <= ERR_NONE;
            q.pcnt   <= '0;
        end else begin
            q <= n;
        end
    end

    assign byte_ready_o = (q.st == ST_FETCH) && rdy_s;
    assign prog_n_o     = q.prog_n;
    assign dclk_o       = q.dclk;
    assign dat_o        = (q.st == ST_SHIFT) ? ser_bit : 1'b0;
    assign busy_o       = (q.st != ST_IDLE);
    assign done_o       = q.done;
    assign err_o        = (q.err != ERR_NONE);
    assign err_code_o   = q.err;

endmodule

// File: rtl/psc_master_chk.sv
module psc_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_ready_o,
    input logic       prog_n_o,
    input logic       dclk_o,
    input logic       dat_o,
    input logic       tgt_ready_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o
);
    // tracks whether the target has reported ready since the last program pulse
    logic seen_rdy_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          seen_rdy_q <= 1'b0;
        else if (!prog_n_o)  seen_rdy_q <= 1'b0;
        else if (tgt_ready_i) seen_rdy_q <= 1'b1;
    end

    a_r1_idle_rest: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!dclk_o && prog_n_o && !byte_ready_o));

    a_r2_pulse_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> busy_o);

    a_r3_clk_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk_o) |-> seen_rdy_q);

    a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk_o && $past(dclk_o)) |-> $stable(dat_o));

    a_r5_wait_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> !dclk_o);

    a_r7_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !err_o));

    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (!dclk_o && prog_n_o));

    a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (!done_o && !err_o));

endmodule

bind psc_master psc_master_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_ready_o (byte_ready_o),
    .prog_n_o     (prog_n_o),
    .dclk_o       (dclk_o),
    .dat_o        (dat_o),
    .tgt_ready_i  (tgt_ready_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/psc_master_tb.sv
module psc_master_tb;
    localparam int DIV        = 4;
    localparam int PULSE_LEN  = 8;
    localparam int TAIL_LIMIT = 6;
    localparam int TRAIL_CLKS = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] byte_data_i = '0;
    logic       byte_valid_i = 1'b0;
    logic       byte_last_i = 1'b0;
    logic       byte_ready_o, prog_n_o, dclk_o, dat_o;
    logic       tgt_ready_i = 1'b1;
    logic       tgt_done_i = 1'b0;
    logic       busy_o, done_o, err_o;
    logic [1:0] err_code_o;

    always #10 clk = ~clk;

    psc_master u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .byte_data_i  (byte_data_i),
        .byte_valid_i (byte_valid_i),
        .byte_last_i  (byte_last_i),
        .byte_ready_o (byte_ready_o),
        .prog_n_o     (prog_n_o),
        .dclk_o       (dclk_o),
        .dat_o        (dat_o),
        .tgt_ready_i  (tgt_ready_i),
        .tgt_done_i   (tgt_done_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o),
        .err_code_o   (err_code_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard and target model state
    bit         exp_q[$];
    logic [7:0] stim[$];
    int  done_after, ready_delay, drop_after;
    int  pre_rises, tail_rises, drain_rises, acc_cnt;
    int  plow, last_plow, prog_falls, hi_len, hi_bad, stall_bad, early_clk, rdy_early;
    int  rcnt;
    bit  drop;
    logic prev_dclk = 1'b0, prev_prog = 1'b1;

    task automatic clear_stats();
        exp_q.delete();
        pre_rises = 0; tail_rises = 0; drain_rises = 0; acc_cnt = 0;
        plow = 0; last_plow = 0; prog_falls = 0; hi_len = 0; hi_bad = 0;
        stall_bad = 0; early_clk = 0; rdy_early = 0; drop = 0;
    endtask

    // monitor and target model, both away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!prog_n_o) plow++;
            if (prog_n_o && !prev_prog) begin last_plow = plow; plow = 0; end
            if (!prog_n_o && prev_prog) prog_falls++;
            if (byte_ready_o && dclk_o) stall_bad++;
            if (byte_ready_o && !tgt_ready_i) rdy_early++;
            if (dclk_o) hi_len++;
            else if (prev_dclk) begin
                if (hi_len != DIV) hi_bad++;
                hi_len = 0;
            end
            if (dclk_o && !prev_dclk) begin
                if (!tgt_ready_i) early_clk++;
                if (tgt_done_i) tail_rises++;
                else begin
                    if (exp_q.size() > 0) begin
                        bit b;
                        b = exp_q.pop_front();
                        chk(dat_o == b, "R4 serial bit", int'(dat_o), int'(b));
                    end else begin
                        drain_rises++;
                    end
                    pre_rises++;
                    if (done_after > 0 && pre_rises == done_after) tgt_done_i = 1'b1;
                    if (drop_after > 0 && pre_rises == drop_after) drop = 1;
                end
            end
            // target status model
            if (!prog_n_o) begin
                tgt_ready_i = 1'b0; tgt_done_i = 1'b0; rcnt = 0; drop = 0;
            end else if (drop) begin
                tgt_ready_i = 1'b0;
            end else if (!tgt_ready_i && ready_delay >= 0) begin
                if (rcnt >= ready_delay) tgt_ready_i = 1'b1;
                rcnt++;
            end
        end
        prev_dclk = dclk_o;
        prev_prog = prog_n_o;
    end

    // driver: offers the bytes and records the expected bits on acceptance
    task automatic run_cfg(input int gap, input bit poke);
        clear_stats();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk(busy_o && !err_o && !done_o, "R11 start clears status",
            {busy_o, err_o, done_o}, 3'b100);
        for (int i = 0; i < stim.size(); i++) begin
            for (int g = 0; g < gap && busy_o; g++) @(negedge clk);
            byte_valid_i = 1'b1;
            byte_data_i  = stim[i];
            byte_last_i  = (i == stim.size() - 1);
            while (busy_o && !byte_ready_o) @(negedge clk);
            if (!busy_o) break;
            for (int k = 0; k < 8; k++) exp_q.push_back(stim[i][k]);
            acc_cnt++;
            @(negedge clk) byte_valid_i = 1'b0;
            if (poke && i == 0) begin
                start_i = 1'b1;
                @(negedge clk) start_i = 1'b0;
            end
        end
        byte_valid_i = 1'b0;
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        done_after = 0; ready_delay = 0; drop_after = 0;
        clear_stats();
        repeat (3) @(negedge clk);
        chk(prog_n_o && !dclk_o && !busy_o && !byte_ready_o, "R1 levels in reset",
            {prog_n_o, dclk_o, busy_o, byte_ready_o}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!done_o && !err_o && err_code_o == 0, "R1 status after reset",
            {done_o, err_o, err_code_o}, 0);

        // completion exactly on the last bit of the last byte
        stim = '{8'h02, 8'h1B, 8'hEE}; done_after = 24; ready_delay = 20; drop_after = 0;
        run_cfg(0, 0);
        chk(last_plow == PULSE_LEN, "R2 program pulse length", last_plow, PULSE_LEN);
        chk(early_clk == 0 && rdy_early == 0, "R3 nothing before ready", early_clk + rdy_early, 0);
        chk(pre_rises == 24, "R6 bits before completion", pre_rises, 24);
        chk(drain_rises == 0, "R7 no drain on coincident end", drain_rises, 0);
        chk(tail_rises == TRAIL_CLKS, "R7 trailing clocks", tail_rises, TRAIL_CLKS);
        chk(done_o && !err_o, "R7 done flag", {done_o, err_o}, 2'b10);
        chk(hi_bad == 0, "R5 high phase width", hi_bad, 0);
        chk(prog_n_o && !dclk_o && !busy_o, "R1 idle after finish", {prog_n_o, dclk_o, busy_o}, 3'b100);

        // completion in the middle of the second byte
        stim = '{8'hA5, 8'h3C, 8'hF0, 8'h0F}; done_after = 12; ready_delay = 3;
        run_cfg(0, 0);
        chk(acc_cnt == 2, "R6 bytes consumed", acc_cnt, 2);
        chk(pre_rises == 12, "R6 bits before completion", pre_rises, 12);
        chk(tail_rises == TRAIL_CLKS && done_o, "R7 trailing after early completion",
            tail_rises, TRAIL_CLKS);

        // stalled input plus an ignored start request
        stim = '{8'h81, 8'h7E, 8'hC3}; done_after = 24; ready_delay = 0;
        run_cfg(25, 1);
        chk(stall_bad == 0, "R5 clock low while waiting", stall_bad, 0);
        chk(hi_bad == 0, "R5 high phase width with stalls", hi_bad, 0);
        chk(prog_falls == 1, "R2 start ignored while busy", prog_falls, 1);
        chk(done_o && acc_cnt == 3, "R2 transfer undisturbed", acc_cnt, 3);

        // completion arrives inside the drain window
        stim = '{8'h5A}; done_after = 11;
        run_cfg(0, 0);
        chk(drain_rises == 3, "R10 drain pulses before completion", drain_rises, 3);
        chk(done_o && tail_rises == TRAIL_CLKS, "R10 finish through trailing clocks",
            tail_rises, TRAIL_CLKS);

        // completion never arrives
        stim = '{8'hFF}; done_after = 0;
        run_cfg(0, 0);
        chk(err_o && err_code_o == 2'd3, "R10 no-completion code", err_code_o, 3);
        chk(drain_rises == TAIL_LIMIT, "R10 drain pulse count", drain_rises, TAIL_LIMIT);
        chk(!done_o, "R10 no done flag", done_o, 0);

        // target never reports ready
        stim = '{8'h11}; ready_delay = -1;
        run_cfg(0, 0);
        chk(err_o && err_code_o == 2'd1, "R8 ready timeout code", err_code_o, 1);
        chk(pre_rises == 0 && acc_cnt == 0, "R8 nothing sent", pre_rises + acc_cnt, 0);

        // status lost after five bits
        stim = '{8'h33, 8'hCC}; ready_delay = 2; done_after = 0; drop_after = 5;
        run_cfg(0, 0);
        chk(err_o && err_code_o == 2'd2, "R9 status lost code", err_code_o, 2);
        chk(pre_rises == 5, "R9 no edge after loss", pre_rises, 5);
        chk(!dclk_o && prog_n_o && !busy_o, "R9 lines at rest", {dclk_o, prog_n_o, busy_o}, 3'b010);

        // recovery after an error
        stim = '{8'h96}; drop_after = 0; done_after = 8; ready_delay = 1;
        run_cfg(0, 0);
        chk(done_o && !err_o && err_code_o == 0, "R11 clean run after error",
            {done_o, err_o, err_code_o}, 4'b1000);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule